// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block works out the baud rate of a serial line from one received start bit. Once armed, it measures how many system clocks the line stays low after a falling edge and stores that figure in a read-only count register. It then turns the figure into a divisor for a receiver that oversamples each bit 16 times. The divisor is either computed straight from the count or snapped to the nearest entry in a fixed set of common rates.

A small register port holds four control bits. It also gives access to the count and to a sticky lock interrupt. When the hardware-load mode is on, the block writes the divisor into its low and high latch outputs by itself at lock. Those latches are loaded with no divisor-latch access bit involved. After lock, the detector stays parked until software disarms it and arms it again, so later data bits cannot disturb the result.

Top module: `uart_autobaud`

## Requirements
- R1: Register map by `reg_addr`: 0 is control, 1 is the count, 2 is the interrupt (bit 0 reads the pending flag), 3 reads zero. Control bits: 0 arms detection, 1 enables the lock interrupt, 2 enables hardware loading of the divisor latches, 3 selects table mode. Bits 31:4 of control read as zero and ignore writes. After reset, control, count, interrupt and both divisor bytes are 0.
- R2: When armed, the count is the number of clocks that `rx_in` was held low, from the falling edge to the next rising edge. `rx_in` passes through a two-flop synchronizer first, and the detector waits one clock after arming before it watches for a falling edge.
- R3: The count register changes only at lock. Writes to address 1 have no effect.
- R4: After a lock, further low pulses are not measured until control bit 0 has been cleared and set again.
- R5: At lock with bit 1 set, `irq` rises and stays high until a write to address 2 with data bit 0 set. A lock in the same cycle wins over the clear. With bit 1 clear, a lock does not raise `irq`.
- R6: At lock with bits 0 and 2 set, `div_lo` and `div_hi` take the divisor, and `div_wr` pulses for exactly one clock.
- R7: At lock with bit 2 clear, `div_lo`, `div_hi` and `div_wr` are unchanged.
- R8: In formula mode (bit 3 = 0), the divisor is floor((count + 8) / 16). A result of 0 becomes 1, and a result above 65535 becomes 65535.
- R9: In table mode, the divisor is the table entry closest to the formula divisor. The table holds round(CLK_HZ / (16 x rate)) for the rates 300, 1200, 2400, 4800, 9600, 19200, 38400, 57600 and 115200. When two entries are equally close, the larger divisor (the slower rate) is chosen.
- R10: A low pulse shorter than MIN_CNT clocks is thrown away without a lock. The detector then waits for the next falling edge.
- R11: The measuring counter saturates at 2^CNT_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| reg_addr | input | 2 | Register address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Sticky lock interrupt request |
| div_lo | output | 8 | Divisor latch, low byte |
| div_hi | output | 8 | Divisor latch, high byte |
| div_wr | output | 1 | One-clock strobe when the latches are loaded |

## Verification
The assertions check the invariants on every cycle:
- reserved control bits read zero;
- the count holds between locks;
- the interrupt is sticky until it is cleared and rises only on a lock;
- the load strobe is a single cycle;
- the latches never move without it;
- a loaded divisor is never zero.

Only the bench scenarios can show that the measured count, the rounding, the table snapping with its tie rule, the glitch rejection, the saturation and the re-arm rule give the right numbers. There, a behavioural model is compared against every output on every clock.

// File: rtl/uart_ab_pkg.sv
// Shared types and constants for the auto-baud detector.
// Assumes the clock frequency is at least 16x the fastest rate in the table.
package uart_ab_pkg;

    localparam int NUM_RATES = 9;
    localparam int DIV_W     = 16;

    typedef enum logic [1:0] {
        MS_OFF   = 2'd0,
        MS_WAIT  = 2'd1,
        MS_COUNT = 2'd2,
        MS_HELD  = 2'd3
    } meas_state_t;

    typedef struct packed {
        logic tbl;   // bit 3: snap to table
        logic hwp;   // bit 2: hardware loads latches
        logic ie;    // bit 1: lock interrupt enable
        logic en;    // bit 0: arm detection
    } ab_ctrl_t;

    // Baud rate of table slot idx, slowest first.
    function automatic longint rate_of(input int idx);
        case (idx)
            0:       return 64'd300;
            1:       return 64'd1200;
            2:       return 64'd2400;
            3:       return 64'd4800;
            4:       return 64'd9600;
            5:       return 64'd19200;
            6:       return 64'd38400;
            7:       return 64'd57600;
            default: return 64'd115200;
        endcase
    endfunction

    // Rounded 16x divisor of table slot idx, clamped to 1..65535.
    function automatic int div_for(input longint clk_hz, input int idx);
        longint b;
        longint d;
        b = rate_of(idx);
        d = (clk_hz + 8 * b) / (16 * b);
        if (d < 1)
            d = 1;
        if (d > 65535)
            d = 65535;
        return int'(d);
    endfunction

endpackage

// File: rtl/uart_ab_sync.sv
// Two-flop synchronizer on the receive line with edge detection.
// Assumes the line idles high; all stages reset to 1 so no edge is seen at reset.
module uart_ab_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);

    logic s1_q;
    logic s2_q;
    logic prev_q;

    // Synchronize the line and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= rx_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign rx_s = s2_q;
    assign fall = prev_q & ~s2_q;

endmodule

// File: rtl/uart_ab_measure.sv
// Start-bit width measurement. After arming it waits for a falling edge and
// counts low clocks, saturating. On the rising edge it either reports a lock
// (one-cycle pulse plus value) or drops the pulse as a glitch. After a lock it
// parks until disarmed. Assumes en comes from a register.
module uart_ab_measure #(
    parameter int CNT_W   = 20,
    parameter int MIN_CNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_s,
    input  logic             fall,
    output logic             lock,
    output logic [CNT_W-1:0] meas
);
    import uart_ab_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CNT);

    meas_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;

    // State machine, counter and lock reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= MS_OFF;
            cnt_q <= '0;
            lock  <= 1'b0;
            meas  <= '0;
        end else begin
            lock <= 1'b0;
            if (!en) begin
                st_q <= MS_OFF;
            end else begin
                case (st_q)
                    MS_OFF:  st_q <= MS_WAIT;
                    MS_WAIT: begin
                        if (fall) begin
                            cnt_q <= CNT_W'(1);
                            st_q  <= MS_COUNT;
                        end
                    end
                    MS_COUNT: begin
                        if (rx_s) begin
                            if (cnt_q >= CNT_MIN) begin
                                meas <= cnt_q;
                                lock <= 1'b1;
                                st_q <= MS_HELD;
                            end else begin
                                st_q <= MS_WAIT;
                            end
                        end else if (cnt_q != CNT_MAX) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: st_q <= MS_HELD;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_ab_divisor.sv
// Combinational divisor from a measured count: rounded count/16 clamped to
// 1..65535, optionally snapped to the nearest table entry (ties to the larger
// divisor). Assumes CNT_W <= 31.
module uart_ab_divisor #(
    parameter longint CLK_HZ = 64'd50_000_000,
    parameter int     CNT_W  = 20
) (
    input  logic [CNT_W-1:0]                  count,
    input  logic                              use_tbl,
    output logic [uart_ab_pkg::DIV_W-1:0]     div
);
    import uart_ab_pkg::*;

    logic [31:0]      rounded;
    logic [DIV_W-1:0] formula;
    logic [DIV_W-1:0] tab [NUM_RATES];
    logic [DIV_W-1:0] snapped;

    assign rounded = (32'(count) + 32'd8) >> 4;

    // Clamp the rounded quotient into the legal divisor range.
    always_comb begin
        if (rounded == 32'd0)
            formula = DIV_W'(1);
        else if (rounded > 32'd65535)
            formula = {DIV_W{1'b1}};
        else
            formula = rounded[DIV_W-1:0];
    end

    for (genvar k = 0; k < NUM_RATES; k++) begin : g_tab
        localparam int TD = div_for(CLK_HZ, k);
        assign tab[k] = DIV_W'(TD);
    end

    // Nearest-entry search; strict compare keeps the earlier (slower) entry on ties.
    always_comb begin
        logic [DIV_W-1:0] best_d;
        logic [DIV_W-1:0] d;
        snapped = tab[0];
        best_d  = (formula > tab[0]) ? formula - tab[0] : tab[0] - formula;
        for (int k = 1; k < NUM_RATES; k++) begin
            d = (formula > tab[k]) ? formula - tab[k] : tab[k] - formula;
            if (d < best_d) begin
                best_d  = d;
                snapped = tab[k];
            end
        end
    end

    assign div = use_tbl ? snapped : formula;

endmodule

// File: rtl/uart_ab_regs.sv
// Control, count and interrupt registers, plus the divisor latch pair.
// Everything is captured one clock after the lock pulse. The read mux is combinational.
module uart_ab_regs #(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wen,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic                          lock,
    input  logic [CNT_W-1:0]              meas,
    input  logic [uart_ab_pkg::DIV_W-1:0] new_div,
    output uart_ab_pkg::ab_ctrl_t         ctrl,
    output logic [CNT_W-1:0]              count_q,
    output logic                          irq,
    output logic [7:0]                    div_lo,
    output logic [7:0]                    div_hi,
    output logic                          div_wr
);
    import uart_ab_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(2);

    logic irq_clr;
    logic unused_wbits;

    assign irq_clr      = reg_wen && (reg_addr == A_IRQ) && reg_wdata[0];
    assign unused_wbits = ^reg_wdata[DATA_W-1:4];

    // Control register: only the four defined bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (reg_wen && reg_addr == A_CTRL)
            ctrl <= ab_ctrl_t'(reg_wdata[3:0]);
    end

    // Count register, written only at lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (lock)
            count_q <= meas;
    end

    // Sticky interrupt: a lock outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (lock && ctrl.ie)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    // Divisor latch load by hardware at lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= '0;
            div_hi <= '0;
            div_wr <= 1'b0;
        end else begin
            div_wr <= 1'b0;
            if (lock && ctrl.en && ctrl.hwp) begin
                div_lo <= new_div[7:0];
                div_hi <= new_div[15:8];
                div_wr <= 1'b1;
            end
        end
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = DATA_W'(ctrl);
            A_CNT:   reg_rdata = DATA_W'(count_q);
            A_IRQ:   reg_rdata = DATA_W'(irq);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_autobaud.sv
// Top of the auto-baud detector: synchronizer, start-bit measurement, divisor
// computation and register/latch stage. Assumes rx_in idles high and that the
// register port is in the clk domain.
module uart_autobaud #(
    parameter longint CLK_HZ  = 64'd50_000_000,
    parameter int     CNT_W   = 20,
    parameter int     MIN_CNT = 8,
    parameter int     ADDR_W  = 2,
    parameter int     DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [7:0]        div_lo,
    output logic [7:0]        div_hi,
    output logic              div_wr
);
    import uart_ab_pkg::*;

    logic             rx_s;
    logic             fall;
    logic             lock;
    logic [CNT_W-1:0] meas;
    logic [DIV_W-1:0] new_div;
    logic [CNT_W-1:0] count_q;
    ab_ctrl_t         ctrl;

    uart_ab_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    uart_ab_measure #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_meas (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.en),
        .rx_s  (rx_s),
        .fall  (fall),
        .lock  (lock),
        .meas  (meas)
    );

    uart_ab_divisor #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_div (
        .count   (meas),
        .use_tbl (ctrl.tbl),
        .div     (new_div)
    );

    uart_ab_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lock      (lock),
        .meas      (meas),
        .new_div   (new_div),
        .ctrl      (ctrl),
        .count_q   (count_q),
        .irq       (irq),
        .div_lo    (div_lo),
        .div_hi    (div_hi),
        .div_wr    (div_wr)
    );

endmodule

// File: rtl/uart_autobaud_chk.sv
// Property checker bound to uart_autobaud; observes ports and the internal lock pulse.
module uart_autobaud_chk #(
    parameter int CNT_W  = 20,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wen,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [7:0]        div_lo,
    input logic [7:0]        div_hi,
    input logic              div_wr,
    input logic              lock,
    input logic [CNT_W-1:0]  count_q
);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:4] == '0));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> $stable(count_q));

    assert_lock_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !lock);

    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wen && reg_addr == ADDR_W'(2) && reg_wdata[0])) |=> irq);

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(lock));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !div_wr);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !div_wr |-> $stable({div_hi, div_lo}));

    assert_div_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |-> ({div_hi, div_lo} != 16'd0));

endmodule

bind uart_autobaud uart_autobaud_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .div_lo    (div_lo),
    .div_hi    (div_hi),
    .div_wr    (div_wr),
    .lock      (lock),
    .count_q   (count_q)
);

// File: tb/tb_uart_autobaud.sv
// Bench: behavioural reference model compared on every clock plus named scenario checks.
module tb_uart_autobaud;

    localparam longint CLK_HZ  = 64'd1_843_200;
    localparam int     CNT_W   = 13;
    localparam int     MIN_CNT = 4;
    localparam int     CMAX    = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  div_lo;
    logic [7:0]  div_hi;
    logic        div_wr;

    int n_vec = 0;
    int n_bad = 0;
    int n_strobe = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_autobaud #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .div_lo(div_lo), .div_hi(div_hi), .div_wr(div_wr)
    );

    // Expected divisor from the requirement text (R8, R9).
    function automatic int ref_div(input int cnt, input bit tbl);
        int f, best, bd, d, t;
        int rates[9] = '{300, 1200, 2400, 4800, 9600, 19200, 38400, 57600, 115200};
        f = (cnt + 8) / 16;
        if (f == 0) f = 1;
        if (f > 65535) f = 65535;
        if (!tbl) return f;
        best = -1; bd = 0;
        foreach (rates[i]) begin
            t = int'((CLK_HZ + 8 * rates[i]) / (16 * rates[i]));
            d = (f > t) ? f - t : t - f;
            if (best < 0 || d < bd) begin best = t; bd = d; end
        end
        return best;
    endfunction

    // Reference model state (after each edge).
    int m_s1, m_s2, m_prev, m_phase, m_cnt, m_lock, m_meas;
    int m_ctrl, m_count, m_irq, m_div, m_wr;
    int o_s2, o_prev, o_phase, o_cnt, o_lock, o_meas, o_ctrl, dv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_phase = 0; m_cnt = 0; m_lock = 0;
            m_meas = 0; m_ctrl = 0; m_count = 0; m_irq = 0; m_div = 0; m_wr = 0;
        end else begin
            o_s2 = m_s2; o_prev = m_prev; o_phase = m_phase; o_cnt = m_cnt;
            o_lock = m_lock; o_meas = m_meas; o_ctrl = m_ctrl;
            m_prev = o_s2; m_s2 = m_s1; m_s1 = int'(rx_in);
            m_wr = 0;
            if (reg_wen && reg_addr == 2 && reg_wdata[0]) m_irq = 0;
            if (o_lock) begin
                m_count = o_meas;
                if (o_ctrl & 2) m_irq = 1;
                if ((o_ctrl & 5) == 5) begin
                    dv = ref_div(o_meas, o_ctrl[3]);
                    m_div = dv; m_wr = 1;
                end
            end
            m_lock = 0;
            if (!(o_ctrl & 1)) m_phase = 0;
            else if (o_phase == 0) m_phase = 1;
            else if (o_phase == 1) begin
                if (o_prev == 1 && o_s2 == 0) begin m_cnt = 1; m_phase = 2; end
            end else if (o_phase == 2) begin
                if (o_s2 == 1) begin
                    if (o_cnt >= MIN_CNT) begin m_meas = o_cnt; m_lock = 1; m_phase = 3; end
                    else m_phase = 1;
                end else if (o_cnt < CMAX) m_cnt = o_cnt + 1;
            end
            if (reg_wen && reg_addr == 0) m_ctrl = int'(reg_wdata[3:0]);
        end
    end

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_count;
            2: return m_irq;
            default: return 0;
        endcase
    endfunction

    // Per-clock comparison against the model, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            n_vec++;
            if (reg_rdata !== 32'(exp_rdata(int'(reg_addr))) || irq !== m_irq[0] ||
                {div_hi, div_lo} !== 16'(m_div) || div_wr !== m_wr[0]) begin
                n_bad++;
                $display("FAIL R1/R2/R5/R6 per-clock: rdata=%0h irq=%0b div=%0d wr=%0b exp rdata=%0h irq=%0d div=%0d wr=%0d",
                         reg_rdata, irq, {div_hi, div_lo}, div_wr,
                         exp_rdata(int'(reg_addr)), m_irq, m_div, m_wr);
            end
            if (div_wr) n_strobe++;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 2'(a); reg_wdata = 32'(d); reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 2'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic low_pulse(input int n);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (n) @(negedge clk);
        rx_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic rearm(input int c);
        wr(0, 0);
        wr(0, c);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        int v;
        int s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rd(0, v); chk("R1 reset ctrl", v, 0);
        rd(1, v); chk("R1 reset count", v, 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset divisor", int'({div_hi, div_lo}), 0);

        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R1 reserved bits", v, 15);
        wr(1, 123); rd(1, v); chk("R3 count write ignored", v, 0);

        rearm(7); s0 = n_strobe;
        low_pulse(200);
        rd(1, v); chk("R2 measured count", v, 200);
        chk("R5 irq at lock", int'(irq), 1);
        chk("R8 formula divisor 200", int'({div_hi, div_lo}), 13);
        chk("R6 single strobe", n_strobe - s0, 1);

        low_pulse(50);
        rd(1, v); chk("R4 no re-measure after lock", v, 200);
        chk("R6 no extra strobe", n_strobe - s0, 1);

        wr(2, 1); chk("R5 irq cleared", int'(irq), 0);

        rearm(15);
        low_pulse(3);
        chk("R10 glitch no irq", int'(irq), 0);
        rd(1, v); chk("R10 glitch count kept", v, 200);
        low_pulse(200);
        chk("R9 table snap 13->12", int'({div_hi, div_lo}), 12);

        rearm(15);
        low_pulse(144);
        chk("R9 tie to larger divisor", int'({div_hi, div_lo}), 12);

        wr(2, 1); rearm(3); s0 = n_strobe;
        low_pulse(100);
        rd(1, v); chk("R7 count without load", v, 100);
        chk("R7 latches untouched", int'({div_hi, div_lo}), 12);
        chk("R7 no strobe", n_strobe - s0, 0);

        wr(2, 1); rearm(5);
        low_pulse(5);
        chk("R8 zero forced to one", int'({div_hi, div_lo}), 1);
        chk("R5 no irq when disabled", int'(irq), 0);

        rearm(5);
        low_pulse(8300);
        rd(1, v); chk("R11 counter saturates", v, CMAX);
        chk("R8 divisor at saturation", int'({div_hi, div_lo}), 512);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule